// File: doc/BRIEF.md
# Glitch-free programmable clock-enable divider

This block divides a fast source clock by a power-of-two factor, chosen by a 4-bit code, and produces one enable pulse per divided period. The same pulse goes to four consumers: the processor, the I/O peripherals, the converter and the memory. It produces no derived clocks. Downstream flops stay on the source clock and use the enables to qualify their updates. A free-running phase counter runs on the undivided clock, and every pulse position is derived from it.

Software changes the rate with a single write strobe and a code. The code goes into a pending register. It takes effect only at a point that ends a period of the old setting and also of the new one, which is a multiple of the larger of the two factors. Because of this, no interval between pulses is ever shorter than the faster of the two periods, and no pulse is cut short. How long the change takes depends on where the counter is when the write arrives.

Top module: `clk_prescaler`

## Requirements
- R1: The four enable outputs `en_cpu`, `en_io`, `en_conv` and `en_mem` are equal in every cycle.
- R2: The division factor is 2^N, where N is the applied code. Source edges are counted from reset release, with the first edge numbered 1. The enables are high in the cycle after edge e exactly when e is a multiple of the factor that was in force before that edge.
- R3: A written code from 9 to 15 acts as code 8 (factor 256), and `active_code` then reads 8.
- R4: A pending code is applied at the first edge, after the edge that sampled the write, whose number is a multiple of the larger factor of the old and new settings. The enable at that edge still follows the old setting. The delay therefore depends on the counter phase.
- R5: With a nonzero applied code, every enable pulse lasts exactly one source cycle. With code 0 the enables stay high in every cycle.
- R6: A write that arrives while an earlier code is still pending replaces that code. Only the last code written is ever applied.
- R7: While `rst_n` is low, all enables are low and `active_code` reads 3 (factor 8). The phase counter restarts from zero.
- R8: `active_code` shows the applied code and changes only at the switch edge described in R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Undivided source clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-cycle strobe that writes a new division code |
| wr_code | input | 4 | Division code N, factor 2^N |
| en_cpu | output | 1 | Processor clock enable |
| en_io | output | 1 | I/O clock enable |
| en_conv | output | 1 | Converter clock enable |
| en_mem | output | 1 | Memory clock enable |
| active_code | output | 4 | Code currently applied |

## Verification
The bench writes codes at arbitrary counter phases and predicts the exact edge of each switch. A design that switched on the old boundary alone, rather than the common one, would emit a shortened interval or move the pulse grid, and the per-cycle enable comparison would catch it. The bench also covers out-of-range codes, which would alias to small factors if the clamp were missing. It covers code 0, where a design that forced one-cycle pulses would drop enables. Finally, it issues back-to-back writes while a change is pending, where a design that applied the first value would visit a rate nobody asked for.

// File: rtl/prescale_pkg.sv
package prescale_pkg;
  localparam int CODE_W   = 4;
  localparam int MAX_CODE = 8;
  localparam int CNT_W    = MAX_CODE;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [CNT_W-1:0]  phase_t;

  // Limit a written code to the deepest division the counter supports.
  function automatic code_t clamp_code(input code_t c);
    return (c > code_t'(MAX_CODE)) ? code_t'(MAX_CODE) : c;
  endfunction

  // Low-bit mask whose all-ones state marks the last cycle of a period.
  function automatic phase_t period_mask(input code_t c);
    logic [CNT_W:0] t;
    t = ({{CNT_W{1'b0}}, 1'b1} << c) - 1'b1;
    return t[CNT_W-1:0];
  endfunction

  // The slower of two settings decides the shared boundary.
  function automatic code_t slower_code(input code_t a, input code_t b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic at_boundary(input phase_t p, input code_t c);
    return (p & period_mask(c)) == period_mask(c);
  endfunction
endpackage

// File: rtl/phase_counter.sv
module phase_counter
  import prescale_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  output phase_t phase
);
  always_ff @(posedge clk) begin
    if (!rst_n) phase <= '0;
    else        phase <= phase + 1'b1;
  end
endmodule

// File: rtl/code_update.sv
module code_update
  import prescale_pkg::*;
#(
  parameter int RESET_CODE = 3
) (
  input  logic   clk,
  input  logic   rst_n,
  input  phase_t phase,
  input  logic   wr_en,
  input  code_t  wr_code,
  output code_t  active_code,
  output code_t  pend_code,
  output logic   pend_valid,
  output logic   sync_pt
);
  code_t join_code;

  always_comb begin
    join_code = slower_code(active_code, pend_code);
    sync_pt   = pend_valid && at_boundary(phase, join_code);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_code <= code_t'(RESET_CODE);
      pend_code   <= code_t'(RESET_CODE);
      pend_valid  <= 1'b0;
    end else begin
      if (sync_pt) begin
        active_code <= pend_code;
        pend_valid  <= 1'b0;
      end
      if (wr_en) begin
        pend_code  <= clamp_code(wr_code);
        pend_valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/enable_gen.sv
module enable_gen
  import prescale_pkg::*;
#(
  parameter int NUM_DOMAINS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  phase_t                 phase,
  input  code_t                  active_code,
  output logic [NUM_DOMAINS-1:0] en
);
  logic tick;

  always_comb tick = at_boundary(phase, active_code);

  for (genvar d = 0; d < NUM_DOMAINS; d++) begin : g_dom
    always_ff @(posedge clk) begin
      if (!rst_n) en[d] <= 1'b0;
      else        en[d] <= tick;
    end
  end
endmodule

// File: rtl/clk_prescaler.sv
module clk_prescaler
  import prescale_pkg::*;
#(
  parameter int RESET_CODE = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [3:0] wr_code,
  output logic       en_cpu,
  output logic       en_io,
  output logic       en_conv,
  output logic       en_mem,
  output logic [3:0] active_code
);
  localparam int NUM_DOMAINS = 4;

  phase_t                 phase_cnt;
  code_t                  pend_code;
  logic                   pend_valid;
  logic                   sync_pt;
  logic [NUM_DOMAINS-1:0] dom_en;

  phase_counter u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .phase (phase_cnt)
  );

  code_update #(.RESET_CODE(RESET_CODE)) u_upd (
    .clk         (clk),
    .rst_n       (rst_n),
    .phase       (phase_cnt),
    .wr_en       (wr_en),
    .wr_code     (wr_code),
    .active_code (active_code),
    .pend_code   (pend_code),
    .pend_valid  (pend_valid),
    .sync_pt     (sync_pt)
  );

  enable_gen #(.NUM_DOMAINS(NUM_DOMAINS)) u_en (
    .clk         (clk),
    .rst_n       (rst_n),
    .phase       (phase_cnt),
    .active_code (active_code),
    .en          (dom_en)
  );

  assign en_cpu  = dom_en[0];
  assign en_io   = dom_en[1];
  assign en_conv = dom_en[2];
  assign en_mem  = dom_en[3];
endmodule

// File: rtl/prescale_checker.sv
module prescale_checker
  import prescale_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input phase_t phase,
  input logic   sync_pt,
  input code_t  pend_code,
  input code_t  active_code,
  input logic   en_cpu,
  input logic   en_io,
  input logic   en_conv,
  input logic   en_mem
);
  assert_domains_equal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (en_cpu == en_io) && (en_cpu == en_conv) && (en_cpu == en_mem));

  assert_pulse_on_grid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en_cpu |-> ((phase & period_mask($past(active_code))) == '0));

  assert_code_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    active_code <= code_t'(MAX_CODE));

  assert_switch_loads_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pt |=> active_code == $past(pend_code));

  assert_single_cycle_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_cpu && active_code != '0) |=> !en_cpu);

  assert_change_only_at_sync_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (active_code != $past(active_code)) |-> $past(sync_pt));
endmodule

bind clk_prescaler prescale_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .phase       (phase_cnt),
  .sync_pt     (sync_pt),
  .pend_code   (pend_code),
  .active_code (active_code),
  .en_cpu      (en_cpu),
  .en_io       (en_io),
  .en_conv     (en_conv),
  .en_mem      (en_mem)
);

// File: tb/sim_clk_prescaler.sv
module sim_clk_prescaler;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_code = '0;
  logic       en_cpu, en_io, en_conv, en_mem;
  logic [3:0] active_code;

  int    n_cmp = 0;
  int    n_bad = 0;
  string phase_req = "R2";
  bit    done = 1'b0;

  typedef struct { logic en; int code; } exp_t;
  exp_t exp_q[$];

  // Bench-side model state, kept from the requirements.
  int  edge_no = 0;
  int  m_act = 3;
  int  m_pend = 3;
  bit  m_pv = 1'b0;

  always #4 clk = ~clk;

  clk_prescaler u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_code(wr_code),
    .en_cpu(en_cpu), .en_io(en_io), .en_conv(en_conv), .en_mem(en_mem),
    .active_code(active_code)
  );

  function automatic int fac(input int c);
    return 1 << ((c > 8) ? 8 : c);
  endfunction

  task automatic check(input string req, input string what, input int act, input int expv);
    n_cmp++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at edge %0d", req, what, act, expv, edge_no);
    end
  endtask

  // Predictor: one expected item per source edge after reset release.
  always @(posedge clk) begin
    if (rst_n) begin
      exp_t it;
      bit   sw;
      edge_no++;
      it.en = (edge_no % fac(m_act)) == 0;
      sw = m_pv && ((edge_no % fac((m_act > m_pend) ? m_act : m_pend)) == 0);
      if (sw) begin m_act = m_pend; m_pv = 1'b0; end
      if (wr_en) begin m_pend = (wr_code > 8) ? 8 : int'(wr_code); m_pv = 1'b1; end
      it.code = m_act;
      exp_q.push_back(it);
    end
  end

  // Monitor: compares away from the active edge.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t it;
      it = exp_q.pop_front();
      check(phase_req, "en_cpu", int'(en_cpu), int'(it.en));
      check("R8", "active_code", int'(active_code), it.code);
      check("R1", "domain mismatch", int'({en_io, en_conv, en_mem}), en_cpu ? 7 : 0);
    end
  end

  task automatic write_code(input logic [3:0] c);
    @(negedge clk);
    wr_en = 1'b1; wr_code = c;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R7", "reset en", int'({en_cpu, en_io, en_conv, en_mem}), 0);
    check("R7", "reset code", int'(active_code), 3);
    rst_n = 1'b1;
    phase_req = "R2"; run(40);
    run(3);
    phase_req = "R4"; write_code(4'd5); run(100);
    phase_req = "R5"; write_code(4'd0); run(40);
    phase_req = "R4"; write_code(4'd2); run(30);
    phase_req = "R3"; write_code(4'd12); run(600);
    check("R3", "clamped code", int'(active_code), 8);
    phase_req = "R6"; write_code(4'd1); write_code(4'd4); run(300);
    check("R6", "last write wins", int'(active_code), 4);
    phase_req = "R2"; write_code(4'd4); run(50);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule